// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes an asynchronous serial line and turns each incoming character into a parallel byte for a host. An external divider supplies an enable pulse at sixteen times the bit rate. The receiver uses it to find the falling edge of the start bit. It confirms the start bit at its centre and then samples every later bit at its centre. The character is built up in an internal shift register that the host cannot see. When the first stop bit is sampled, the finished byte moves into a holding buffer. The data-ready flag and the error flags are updated at the same moment.

The framing is set on static inputs. The word length is five to eight data bits. Parity can be off, even, odd or stuck at a fixed level. The stop length is one stop bit, or an extended stop (1.5 bits for five-bit words, 2 bits otherwise). The host takes a byte by pulsing a read strobe, which clears data-ready. If a new character completes before the host has read the old one, the new byte replaces the old one and the overrun flag is raised.

Top module: `uart_rx_core`

## Requirements
- R1: After reset `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are 0 and `rx_byte` is 0.
- R2: A start bit is accepted only if the line is still low eight sample ticks after the falling edge is seen. A low pulse shorter than half a bit produces no character.
- R3: Data bits are taken least significant bit first. `wlen` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits. Buffer bits at and above the word length read 0.
- R4: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. `par_even`=1 selects even parity (data plus parity has an even count of ones) and `par_even`=0 selects odd parity. `err_parity` is set when the received bit disagrees.
- R5: With `par_en`=1 and `par_stick`=1, the expected parity bit is the constant inverse of `par_even`. A mismatch sets `err_parity`.
- R6: With `par_en`=0, no parity bit is expected and `err_parity` stays 0.
- R7: `err_frame` is set for a character whose first stop bit samples low. The byte is still delivered.
- R8: With `two_stop`=1, the receiver ignores the line for 16 ticks after sampling the first stop bit (8 ticks when `wlen`=0). A low level in that window does not begin a character.
- R9: A one-cycle `rd_stb` clears `rx_ready` and `err_overrun` on the next clock edge, unless a character completes in the same cycle.
- R10: A character that completes while `rx_ready` is 1 and `rd_stb` is 0 sets `err_overrun`, and its byte replaces the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial data line, idle high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| wlen | input | 2 | Word length code: 5 + wlen data bits |
| two_stop | input | 1 | Extended stop length |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select; inverted stick level |
| par_stick | input | 1 | Stick parity select |
| rd_stb | input | 1 | Host read strobe |
| rx_byte | output | 8 | Received byte, right-aligned |
| rx_ready | output | 1 | Unread byte held in the buffer |
| err_parity | output | 1 | Parity mismatch on the held byte |
| err_frame | output | 1 | First stop bit sampled low |
| err_overrun | output | 1 | Previous unread byte was overwritten |

## Verification
Several rules are checked by the embedded properties on every cycle. A start bit that is high at its centre returns the receiver to idle. The read strobe clears the ready and overrun flags. Overrun never appears without ready. A newly loaded byte carries no bits above the word length. A parity error never appears with parity disabled. The remaining behaviours need stimulus. These are bit order, even, odd and stick parity values, framing errors, the stop-bit hold window and byte replacement on overrun. The bench shows them by sending characters across all word lengths and parity modes and comparing against values it computes itself.

// File: rtl/uart_rx_core.sv
module uart_rx_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic [1:0] wlen,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       rd_stb,
  output logic [7:0] rx_byte,
  output logic       rx_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [3:0] cnt;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic       pbit;
  logic [1:0] sync;

  wire       rxs      = sync[1];
  wire       mid      = tick16 && (cnt == 4'd15);
  wire       done     = (st == S_STOP) && mid;
  wire [7:0] aligned  = sh >> (2'd3 - wlen);
  wire       exp_par  = par_stick ? ~par_even : ((^aligned) ^ ~par_even);
  wire       last_bit = (bitn == ({1'b0, wlen} + 3'd4));
  wire [3:0] hold_end = (wlen == 2'd0) ? 4'd7 : 4'd15;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (tick16) begin
      case (st)
        S_IDLE:
          if (!rxs) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == 4'd7) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= rxs ? S_IDLE : S_DATA;
          end else cnt <= cnt + 4'd1;
        S_DATA: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin
            sh   <= {rxs, sh[7:1]};
            bitn <= bitn + 3'd1;
            if (last_bit) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin
            pbit <= rxs;
            st   <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= two_stop ? S_HOLD : S_IDLE;
        end
        S_HOLD: begin
          cnt <= cnt + 4'd1;
          if (cnt == hold_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done) begin
      rx_byte     <= aligned;
      rx_ready    <= 1'b1;
      err_parity  <= par_en && (pbit != exp_par);
      err_frame   <= ~rxs;
      err_overrun <= rx_ready && !rd_stb;
    end else if (rd_stb) begin
      rx_ready    <= 1'b0;
      err_overrun <= 1'b0;
    end
  end

  p_glitch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick16 && cnt == 4'd7 && rxs) |=> (st == S_IDLE));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && $stable(wlen)) |-> ((rx_byte >> (4'd5 + {2'b0, wlen})) == 8'd0));

  p_no_par_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_ready) && !$past(par_en)) |-> !err_parity);

  p_hold_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |=> (st == S_HOLD || st == S_IDLE));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done) |=> (!rx_ready && !err_overrun));

  p_overrun_needs_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> rx_ready);
endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int CLK_NS = 10;
  localparam int BIT_CLKS = 32;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, tdiv = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, rd_stb = 1'b0;
  logic [7:0] rx_byte;
  logic rx_ready, err_parity, err_frame, err_overrun;
  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;
  always_ff @(posedge clk) tdiv <= ~tdiv;

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tdiv), .wlen(wlen),
    .two_stop(two_stop), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rd_stb(rd_stb), .rx_byte(rx_byte), .rx_ready(rx_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rx_in = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit use_par, input logic pv, input logic stopv);
    hold(1'b0, BIT_CLKS);
    for (int i = 0; i < n; i++) hold(d[i], BIT_CLKS);
    if (use_par) hold(pv, BIT_CLKS);
    hold(stopv, BIT_CLKS);
    rx_in = 1'b1;
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic logic good_par(input logic [7:0] v, input int mode);
    case (mode)
      1: return ~(^v);
      2: return ^v;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [5];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
    repeat (3) @(negedge clk);
    chk(rx_ready == 0 && err_parity == 0 && err_frame == 0 && err_overrun == 0 && rx_byte == 0,
        "R1 reset", {rx_ready, err_parity, err_frame, err_overrun, rx_byte}, 0);
    rst_n = 1'b1;
    hold(1'b1, BIT_CLKS);

    for (int wl = 0; wl < 4; wl++) begin
      for (int mode = 0; mode < 5; mode++) begin
        wlen = wl[1:0];
        par_en = (mode != 0);
        par_even = (mode == 2 || mode == 4);
        par_stick = (mode >= 3);
        for (int p = 0; p < 6; p++) begin
          logic [7:0] d, mask;
          logic pv;
          bit inj;
          inj = (p == 5);
          if (inj && mode == 0) continue;
          d = pats[p % 5];
          mask = 8'hFF >> (3 - wl);
          pv = good_par(d & mask, mode) ^ inj;
          send(d, wl + 5, par_en, pv, 1'b1);
          chk(rx_ready == 1, "R3 ready", rx_ready, 1);
          chk(rx_byte == (d & mask), "R3 data", rx_byte, d & mask);
          if (mode == 0) chk(err_parity == 0, "R6 parity off", err_parity, 0);
          else if (mode < 3) chk(err_parity == inj, "R4 parity", err_parity, inj);
          else chk(err_parity == inj, "R5 stick parity", err_parity, inj);
          chk(err_frame == 0 && err_overrun == 0, "R7 no frame/overrun", {err_frame, err_overrun}, 0);
          do_read();
          chk(rx_ready == 0, "R9 read clears", rx_ready, 0);
        end
      end
    end

    wlen = 2'd3; par_en = 1'b0; par_stick = 1'b0; par_even = 1'b0;
    hold(1'b0, 6);  hold(1'b1, 3 * BIT_CLKS);
    chk(rx_ready == 0, "R2 short glitch", rx_ready, 0);
    hold(1'b0, 12); hold(1'b1, 3 * BIT_CLKS);
    chk(rx_ready == 0, "R2 under half bit", rx_ready, 0);

    send(8'h96, 8, 0, 1'b0, 1'b0);
    chk(err_frame == 1, "R7 frame error", err_frame, 1);
    chk(rx_byte == 8'h96, "R7 byte kept", rx_byte, 8'h96);
    do_read();
    hold(1'b1, 2 * BIT_CLKS);
    chk(rx_ready == 0, "R7 no false start", rx_ready, 0);

    send(8'h11, 8, 0, 1'b0, 1'b1);
    hold(1'b1, BIT_CLKS);
    send(8'h22, 8, 0, 1'b0, 1'b1);
    chk(err_overrun == 1, "R10 overrun", err_overrun, 1);
    chk(rx_byte == 8'h22, "R10 replaced", rx_byte, 8'h22);
    do_read();
    chk(rx_ready == 0 && err_overrun == 0, "R9 clears overrun", {rx_ready, err_overrun}, 0);

    two_stop = 1'b1;
    send(8'h33, 8, 0, 1'b0, 1'b1);
    do_read();
    hold(1'b0, 20); hold(1'b1, 12 * BIT_CLKS);
    chk(rx_ready == 0, "R8 hold ignores low", rx_ready, 0);

    two_stop = 1'b0;
    send(8'h33, 8, 0, 1'b0, 1'b1);
    do_read();
    hold(1'b0, 20); hold(1'b1, 12 * BIT_CLKS);
    chk(rx_ready == 1, "R8 contrast without hold", rx_ready, 1);
    do_read();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule